// File: doc/BRIEF.md
# Interpolation Walk Sequencer

The sequencer paces a resampling engine through an image. It counts pixels inside each interpolation walk, walks inside each row, and rows inside the image. It raises registered status flags at exact points in that sweep. After every walk it pulses an active-low target write strobe for one cycle, and it advances a 12-bit target address after each strobe. It marks the last pixel of every row and signals completion of the image together with the final write.

The three sizes come in on configuration inputs. They are captured when a start pulse is accepted, so they can change freely while a sweep is running. A hold input stops the whole sequencer in place. A registered, active-low output enable releases the strobe and the address bus so that another agent can drive the target memory. The sweep is driven by a two-state machine. `IDLE` waits; the transition *launch* (start high, hold low) loads the configuration and enters `RUN`. `RUN` steps one pixel per cycle; the transition *finish* (last pixel of last walk of last row, hold low) returns to `IDLE`. `IDLE` stays in place until the next launch.

Top module: `walkseq_top`

## Requirements
- R1: After reset, busy, row_end and img_done are low. The output enable register is in its disabled state, so tgt_wr_n and tgt_addr are undriven.
- R2: A start pulse is accepted only in IDLE with hold low. It captures walk_len, walks_per_row and rows_per_image, and from the next cycle one pixel is stepped per cycle. A start pulse during RUN is ignored, and so are configuration changes during RUN.
- R3: tgt_wr_n is low in the cycle right after the last pixel of each walk, and high in every other cycle.
- R4: row_end is high exactly during the last pixel of the last walk of each row.
- R5: img_done is high for one cycle, in the same cycle as the final write strobe of the image. In that cycle the sequencer is already back in IDLE with busy low.
- R6: tgt_addr is cleared to 0 on launch. It increments by one at the end of every strobe cycle and wraps from 4095 to 0.
- R7: oe_n is registered. oe_n high releases tgt_wr_n and tgt_addr from the next cycle on, and oe_n low drives them again from the next cycle on.
- R8: While hold is high, the counters, the state, the strobe, the flags and the address all keep their values.
- R9: A configuration value of 0 is treated as 1.
- R10: busy is high from the cycle after launch through the last pixel of the image, which gives walk_len × walks_per_row × rows_per_image busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, accepted in IDLE with hold low |
| hold | input | 1 | Freezes the sequencer while high |
| walk_len | input | 8 | Pixels per walk (0 means 1) |
| walks_per_row | input | 8 | Walks per row (0 means 1) |
| rows_per_image | input | 8 | Rows per image (0 means 1) |
| oe_n | input | 1 | Registered output enable for strobe and address, active low |
| busy | output | 1 | High while in RUN |
| tgt_wr_n | output | 1 | Target write strobe, active low, tri-state |
| tgt_addr | output | 12 | Target address, tri-state |
| row_end | output | 1 | High during the last pixel of a row |
| img_done | output | 1 | High with the final write strobe |

## Verification
The hardest case is the combination of wrap-around and hold. The address rolls over only after 4096 strobes, and a hold must land in the middle of a sweep, where the flags already stand at a non-trivial point. One configuration with single-pixel walks, 64 walks per row and 65 rows gives 4160 back-to-back strobes. A per-cycle reference model checks the address across the rollover. A separate sweep raises hold at a chosen pixel and checks that every output repeats that pixel's values until hold is released, after which the whole expected timeline shifts by the length of the hold.

// File: rtl/walkseq_pkg.sv
package walkseq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

endpackage

// File: rtl/walkseq_cnt.sv
// Wrapping counter with terminal detect on current and next value.
module walkseq_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         at_last,
    output logic         nxt_last
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    assign at_last = (cnt_q == limit);

    always_comb begin
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = at_last ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    assign nxt_last = (cnt_d == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/walkseq_fsm.sv
// Two-state sweep controller.
module walkseq_fsm
    import walkseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold,
    input  logic final_pix,
    output logic load,
    output logic busy,
    output logic nxt_busy
);
    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start && !hold)     state_d = ST_RUN;   // launch
            ST_RUN:  if (final_pix && !hold) state_d = ST_IDLE;  // finish
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load     = (state_q == ST_IDLE) && start && !hold;
        busy     = (state_q == ST_RUN);
        nxt_busy = (state_d == ST_RUN);
    end
endmodule

// File: rtl/walkseq_flags.sv
// Registered strobe, flags, target address and output enable.
module walkseq_flags #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              load,
    input  logic              walk_end,
    input  logic              img_end,
    input  logic              row_end_d,
    input  logic              oe_n,
    output logic              wr_n_q,
    output logic              row_end_q,
    output logic              done_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic              oe_off_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_n_q    <= 1'b1;
            row_end_q <= 1'b0;
            done_q    <= 1'b0;
        end else if (!hold) begin
            wr_n_q    <= !walk_end;
            row_end_q <= row_end_d;
            done_q    <= img_end;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= '0;
        end else if (!hold && !wr_n_q) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_off_q <= 1'b1;
        end else begin
            oe_off_q <= oe_n;
        end
    end
endmodule

// File: rtl/walkseq_top.sv
module walkseq_top #(
    parameter int PIX_W  = 8,
    parameter int WALK_W = 8,
    parameter int ROW_W  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hold,
    input  logic [PIX_W-1:0]  walk_len,
    input  logic [WALK_W-1:0] walks_per_row,
    input  logic [ROW_W-1:0]  rows_per_image,
    input  logic              oe_n,
    output logic              busy,
    output wire               tgt_wr_n,
    output wire  [ADDR_W-1:0] tgt_addr,
    output logic              row_end,
    output logic              img_done
);
    logic              load;
    logic              nxt_busy;
    logic              step;
    logic              walk_end;
    logic              img_end;
    logic              row_end_d;
    logic              final_pix;
    logic              wr_n_q;
    logic              oe_off_q;
    logic [ADDR_W-1:0] addr_q;

    logic [PIX_W-1:0]  lim_pix_q,  lim_pix_new,  lim_pix;
    logic [WALK_W-1:0] lim_walk_q, lim_walk_new, lim_walk;
    logic [ROW_W-1:0]  lim_row_q,  lim_row_new,  lim_row;

    logic pix_last,  pix_nlast;
    logic walk_last, walk_nlast;
    logic row_last,  row_nlast;

    // Terminal values: size minus one, with zero read as one
    assign lim_pix_new  = (walk_len == '0)       ? '0 : walk_len - 1'b1;
    assign lim_walk_new = (walks_per_row == '0)  ? '0 : walks_per_row - 1'b1;
    assign lim_row_new  = (rows_per_image == '0) ? '0 : rows_per_image - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_pix_q  <= '0;
            lim_walk_q <= '0;
            lim_row_q  <= '0;
        end else if (load) begin
            lim_pix_q  <= lim_pix_new;
            lim_walk_q <= lim_walk_new;
            lim_row_q  <= lim_row_new;
        end
    end

    assign lim_pix  = load ? lim_pix_new  : lim_pix_q;
    assign lim_walk = load ? lim_walk_new : lim_walk_q;
    assign lim_row  = load ? lim_row_new  : lim_row_q;

    walkseq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .hold      (hold),
        .final_pix (final_pix),
        .load      (load),
        .busy      (busy),
        .nxt_busy  (nxt_busy)
    );

    assign step      = busy && !hold;
    assign walk_end  = step && pix_last;
    assign final_pix = pix_last && walk_last && row_last;
    assign img_end   = walk_end && walk_last && row_last;
    assign row_end_d = nxt_busy && pix_nlast && walk_nlast;

    walkseq_cnt #(.W(PIX_W)) u_pix (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (load),
        .inc      (step),
        .limit    (lim_pix),
        .at_last  (pix_last),
        .nxt_last (pix_nlast)
    );

    walkseq_cnt #(.W(WALK_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (load),
        .inc      (walk_end),
        .limit    (lim_walk),
        .at_last  (walk_last),
        .nxt_last (walk_nlast)
    );

    walkseq_cnt #(.W(ROW_W)) u_row (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (load),
        .inc      (walk_end && walk_last),
        .limit    (lim_row),
        .at_last  (row_last),
        .nxt_last (row_nlast)
    );

    walkseq_flags #(.ADDR_W(ADDR_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .load      (load),
        .walk_end  (walk_end),
        .img_end   (img_end),
        .row_end_d (row_end_d),
        .oe_n      (oe_n),
        .wr_n_q    (wr_n_q),
        .row_end_q (row_end),
        .done_q    (img_done),
        .addr_q    (addr_q),
        .oe_off_q  (oe_off_q)
    );

    // row_nlast feeds no flag; it keeps the counter interface uniform
    logic unused_ok;
    assign unused_ok = row_nlast;

    assign tgt_wr_n = oe_off_q ? 1'bz : wr_n_q;
    assign tgt_addr = oe_off_q ? {ADDR_W{1'bz}} : addr_q;
endmodule

// File: rtl/walkseq_chk.sv
module walkseq_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              load,
    input logic              busy,
    input logic              walk_end,
    input logic              wr_n_q,
    input logic              row_end_q,
    input logic              done_q,
    input logic [ADDR_W-1:0] addr_q
);
    a_r3_strobe_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_end |=> !wr_n_q);

    a_r3_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !walk_end) |=> wr_n_q);

    a_r4_row_end_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        row_end_q |-> busy);

    a_r5_done_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!wr_n_q && !busy));

    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !wr_n_q && !load) |=> (addr_q == $past(addr_q) + 1'b1));

    a_r8_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(addr_q) && $stable(wr_n_q) && $stable(row_end_q)
                  && $stable(done_q) && $stable(busy)));
endmodule

bind walkseq_top walkseq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .load      (load),
    .busy      (busy),
    .walk_end  (walk_end),
    .wr_n_q    (wr_n_q),
    .row_end_q (row_end),
    .done_q    (img_done),
    .addr_q    (addr_q)
);

// File: tb/walkseq_top_tb_top.sv
module walkseq_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       hold = 1'b0;
    logic [7:0] walk_len = 8'd1;
    logic [7:0] walks_per_row = 8'd1;
    logic [7:0] rows_per_image = 8'd1;
    logic       oe_n = 1'b1;
    logic       busy;
    logic       row_end;
    logic       img_done;
    tri1        tgt_wr_n;
    tri1 [11:0] tgt_addr;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    walkseq_top dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .hold           (hold),
        .walk_len       (walk_len),
        .walks_per_row  (walks_per_row),
        .rows_per_image (rows_per_image),
        .oe_n           (oe_n),
        .busy           (busy),
        .tgt_wr_n       (tgt_wr_n),
        .tgt_addr       (tgt_addr),
        .row_end        (row_end),
        .img_done       (img_done)
    );

    // {walk_len, walks_per_row, rows_per_image, expected strobes}
    localparam logic [39:0] VEC [6] = '{
        {8'd2, 8'd2, 8'd1, 16'd2},
        {8'd1, 8'd1, 8'd1, 16'd1},
        {8'd3, 8'd2, 8'd2, 16'd4},
        {8'd1, 8'd3, 8'd2, 16'd6},
        {8'd4, 8'd1, 8'd3, 16'd3},
        {8'd0, 8'd2, 8'd0, 16'd2}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_cycle(input int k, input int le, input int lw, input int n,
                               input string req);
        bit e_busy, e_re, e_wr, e_done;
        e_busy = (k < n);
        e_re   = (k < n) && (((k + 1) % lw) == 0);
        e_wr   = !((k >= 1) && (k <= n) && ((k % le) == 0));
        e_done = (k == n);
        check(busy === e_busy, req, "busy (R10)", int'(busy), int'(e_busy));
        check(row_end === e_re, req, "row_end (R4)", int'(row_end), int'(e_re));
        check(tgt_wr_n === e_wr, req, "tgt_wr_n (R3)", int'(tgt_wr_n), int'(e_wr));
        check(img_done === e_done, req, "img_done (R5)", int'(img_done), int'(e_done));
        if (!e_wr)
            check(int'(tgt_addr) == (((k / le) - 1) % 4096), req, "tgt_addr (R6)",
                  int'(tgt_addr), ((k / le) - 1) % 4096);
    endtask

    // One sweep with optional hold and ignored start at given pixel
    task automatic run(input int l, input int w, input int r,
                       input int hold_at, input int start_at, input string req);
        int le, we, re, n;
        le = (l == 0) ? 1 : l;   // R9
        we = (w == 0) ? 1 : w;
        re = (r == 0) ? 1 : r;
        n  = le * we * re;
        walk_len       = 8'(l);
        walks_per_row  = 8'(w);
        rows_per_image = 8'(r);
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int k = 0; k <= n + 1; k++) begin
            check_cycle(k, le, le * we, n, req);
            if (k == hold_at) begin
                hold = 1'b1;
                for (int h = 0; h < 3; h++) begin
                    tick();
                    check_cycle(k, le, le * we, n, "R8");
                end
                hold = 1'b0;
            end
            if (k == start_at) begin
                start    = 1'b1;
                walk_len = 8'd5;  // R2: must not take effect mid-run
            end
            tick();
            start = 1'b0;
        end
        check(int'(tgt_addr) == ((we * re) % 4096), "R6", "final address",
              int'(tgt_addr), (we * re) % 4096);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, outputs released (pulled high by the bench)
        check(busy === 1'b0, "R1", "busy", int'(busy), 0);
        check(row_end === 1'b0, "R1", "row_end", int'(row_end), 0);
        check(img_done === 1'b0, "R1", "img_done", int'(img_done), 0);
        check(tgt_addr === 12'hFFF, "R1", "addr undriven", int'(tgt_addr), 4095);
        rst_n = 1'b1;
        tick();
        // R7: enable takes effect one cycle later
        oe_n = 1'b0;
        #1;
        check(tgt_addr === 12'hFFF, "R7", "still undriven", int'(tgt_addr), 4095);
        tick();
        check(tgt_addr === 12'd0, "R7", "driven address", int'(tgt_addr), 0);
        check(tgt_wr_n === 1'b1, "R7", "driven strobe", int'(tgt_wr_n), 1);

        // Vector table
        for (int i = 0; i < 6; i++) begin
            run(int'(VEC[i][39:32]), int'(VEC[i][31:24]), int'(VEC[i][23:16]),
                -1, -1, "R2");
            check(int'(tgt_addr) == int'(VEC[i][15:0]), "R6", "strobe count",
                  int'(tgt_addr), int'(VEC[i][15:0]));
        end

        // R8: hold in the middle of a sweep
        run(3, 2, 2, 4, -1, "R8");
        // R2: start pulse and config change ignored while busy
        run(2, 3, 1, -1, 2, "R2");

        // R2: start ignored while hold is high in IDLE
        hold  = 1'b1;
        start = 1'b1;
        tick();
        hold  = 1'b0;
        start = 1'b0;
        tick();
        check(busy === 1'b0, "R2", "start under hold", int'(busy), 0);

        // R7: disable then re-enable in IDLE
        oe_n = 1'b1;
        tick();
        check(tgt_addr === 12'hFFF, "R7", "released address", int'(tgt_addr), 4095);
        oe_n = 1'b0;
        tick();
        check(tgt_addr === 12'd3, "R7", "re-driven address", int'(tgt_addr), 3);

        // R6: address wrap across 4160 strobes
        run(1, 64, 65, -1, -1, "R6");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule